// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial slave that gives a host access to a bank of sixteen 10-bit control words and two peak-level readback registers. The host lowers the frame line, shifts in sixteen bits most-significant first on rising serial-clock edges, and raises the frame line to end the transfer. The first four bits carry the register address. The fifth bit selects a read when it is 1. The sixth bit is reserved and must be zero. The last ten bits carry the write data. On a read, the block returns the addressed word on the data line during the last ten bit slots.

All pins are sampled by the block's own system clock through a synchronizer, so the serial clock can be fully asynchronous, provided it runs well below the system clock. The control words are presented as one flat bus for downstream logic. Two peak trackers watch level codes coming from two audio channels. A smaller code means a louder signal. Each tracker holds the smallest code it has seen, and it clears when the host reads it.

Top module: `spi_ctrl_port`

## Requirements
- R1: `spi_miso_oe` is 1 while the synchronized frame line is low and 0 otherwise; `spi_miso` is 0 whenever `spi_miso_oe` is 0.
- R2: A frame is 16 bits, sampled on rising `spi_sck` while `spi_cs_n` is low, most-significant first: bits 15..12 address, bit 11 read (1) / write (0), bit 10 reserved, bits 9..0 data.
- R3: A write takes effect when `spi_cs_n` rises, and only if exactly 16 bits were clocked in, bit 11 is 0 and bit 10 is 0. Shorter frames, longer frames, and frames with bit 10 set change nothing.
- R4: After reset, words 2 to 9 hold 0x3FF and every other word holds 0x000.
- R5: Writes to addresses 10, 11 and 15 are ignored. Address 15 reads as 0, and slots 10, 11 and 15 of `cfg_q` are always 0.
- R6: On a read, `spi_miso` carries data bits 9..0 of the addressed register in frame slots 9..0. Each bit changes after the falling `spi_sck` edge that precedes its slot. In the first six slots `spi_miso` stays 0.
- R7: Reading address 10 (channel 0) or 11 (channel 1) returns the 6-bit peak code in data bits 9..4 and zeros in bits 3..0. The read resets the tracker to code 63 once the header bits are decoded. Code 63 is also the reset value.
- R8: While enabled, a tracker keeps the minimum of its current code and every code presented with its valid strobe.
- R9: Peak samples are ignored unless bit 0 of word 14 is 1.
- R10: Word n of the bank appears on `cfg_q[n*10 +: 10]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame line, low during a transfer |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (0 = high impedance) |
| pk_vld | input | 2 | Per-channel level sample strobe |
| pk_code | input | 12 | Per-channel 6-bit level codes, channel n at [n*6 +: 6] |
| cfg_q | output | 160 | Flat register bank, word n at [n*10 +: 10] |

## Verification
Each serial pin passes two synchronizer flops and one edge register. A pin change therefore takes effect at the third rising system-clock edge after it. A written word shows on `cfg_q`, and a read bit shows on `spi_miso`, no earlier than that edge. A peak sample updates its tracker one edge after its strobe. The bench holds every serial level for eight system clocks. It samples `spi_miso` just before it raises `spi_sck`, and it checks `cfg_q` and read-back values only after the frame has closed and several idle clocks have passed. So no check falls inside a synchronizer window.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
   // default geometry of the register port
   localparam int DEF_ADDR_W    = 4;
   localparam int DEF_DATA_W    = 10;
   localparam int DEF_CODE_W    = 6;
   localparam int DEF_N_PEAK    = 2;
   localparam int DEF_PEAK_BASE = 10;
   localparam int DEF_RSV_ADDR  = 15;
   localparam int DEF_VOL_LO    = 2;
   localparam int DEF_VOL_HI    = 9;
   localparam int DEF_EN_REG    = 14;
   localparam int DEF_EN_BIT    = 0;
   localparam int DEF_SYNC      = 2;
endpackage

// File: rtl/spi_ctrl_sync.sv
module spi_ctrl_sync #(
   parameter int         W       = 3,
   parameter int         STAGES  = spi_ctrl_pkg::DEF_SYNC,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 2) else $error("sync needs at least two stages");

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_ctrl_frame.sv
module spi_ctrl_frame #(
   parameter int ADDR_W = spi_ctrl_pkg::DEF_ADDR_W,
   parameter int DATA_W = spi_ctrl_pkg::DEF_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              miso,
   output logic              miso_oe
);
   localparam int HDR_W = ADDR_W + 2;
   localparam int FRM_W = HDR_W + DATA_W;
   localparam int CNT_W = $clog2(FRM_W + 2);
   localparam logic [CNT_W-1:0] CNT_HDR_M1 = CNT_W'(HDR_W - 1);
   localparam logic [CNT_W-1:0] CNT_HDR    = CNT_W'(HDR_W);
   localparam logic [CNT_W-1:0] CNT_FRM    = CNT_W'(FRM_W);
   localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(FRM_W + 1);

   logic              cs_d, sck_d;
   logic [FRM_W-1:0]  sr;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] tx;
   logic              sck_rise, sck_fall, cs_rise;

   assign sck_rise = sck_s & ~sck_d & ~cs_s;
   assign sck_fall = ~sck_s & sck_d & ~cs_s;
   assign cs_rise  = cs_s & ~cs_d;

   // header bits seen so far: {addr, rw} in sr[ADDR_W:0] before the reserved bit
   assign rd_addr = sr[ADDR_W:1];
   assign rd_stb  = sck_rise && (cnt == CNT_HDR_M1) && sr[0];

   assign wr_addr = sr[FRM_W-1 -: ADDR_W];
   assign wr_data = sr[DATA_W-1:0];
   assign wr_stb  = cs_rise && (cnt == CNT_FRM) && !sr[DATA_W+1] && !sr[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d    <= 1'b1;
         sck_d   <= 1'b0;
         sr      <= '0;
         cnt     <= '0;
         tx      <= '0;
         miso    <= 1'b0;
         miso_oe <= 1'b0;
      end else begin
         cs_d    <= cs_s;
         sck_d   <= sck_s;
         miso_oe <= ~cs_s;
         if (cs_s) begin
            cnt  <= '0;
            tx   <= '0;
            miso <= 1'b0;
         end else begin
            if (sck_rise) begin
               sr <= {sr[FRM_W-2:0], mosi_s};
               if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
               if (cnt == CNT_HDR_M1) tx <= sr[0] ? rd_word : '0;
            end
            if (sck_fall) begin
               if (cnt >= CNT_HDR && cnt < CNT_FRM) begin
                  miso <= tx[DATA_W-1];
                  tx   <= {tx[DATA_W-2:0], 1'b0};
               end else begin
                  miso <= 1'b0;
               end
            end
         end
      end
   end

   // R1: the data line is quiet whenever its driver is disabled
   a_r1_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !miso_oe |-> !miso);

   // R3: a commit never happens while the frame line is still low
   a_r3_commit_on_close: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(!cs_s));
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs #(
   parameter int ADDR_W    = spi_ctrl_pkg::DEF_ADDR_W,
   parameter int DATA_W    = spi_ctrl_pkg::DEF_DATA_W,
   parameter int N_PEAK    = spi_ctrl_pkg::DEF_N_PEAK,
   parameter int PEAK_BASE = spi_ctrl_pkg::DEF_PEAK_BASE,
   parameter int RSV_ADDR  = spi_ctrl_pkg::DEF_RSV_ADDR,
   parameter int VOL_LO    = spi_ctrl_pkg::DEF_VOL_LO,
   parameter int VOL_HI    = spi_ctrl_pkg::DEF_VOL_HI,
   localparam int N_REG    = 1 << ADDR_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_stb,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [N_REG*DATA_W-1:0] cfg_q
);
   for (genvar a = 0; a < N_REG; a++) begin : g_slot
      if ((a >= PEAK_BASE && a < PEAK_BASE + N_PEAK) || a == RSV_ADDR) begin : g_ro
         assign cfg_q[a*DATA_W +: DATA_W] = '0;
      end else begin : g_rw
         localparam logic [DATA_W-1:0] RST =
            (a >= VOL_LO && a <= VOL_HI) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  q <= RST;
            else if (wr_stb && wr_addr == ADDR_W'(a))    q <= wr_data;
         end
         assign cfg_q[a*DATA_W +: DATA_W] = q;
      end
   end

   // R3: without a commit strobe no word moves
   a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(cfg_q));
endmodule

// File: rtl/spi_ctrl_peak.sv
module spi_ctrl_peak #(
   parameter int CODE_W = spi_ctrl_pkg::DEF_CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic              smp_vld,
   input  logic [CODE_W-1:0] smp_code,
   output logic [CODE_W-1:0] code_q
);
   localparam logic [CODE_W-1:0] QUIET = {CODE_W{1'b1}};

   logic [CODE_W-1:0] base, nxt;

   always_comb begin
      base = clr ? QUIET : code_q;
      nxt  = base;
      if (en && smp_vld && smp_code < base) nxt = smp_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= QUIET;
      else        code_q <= nxt;
   end

   // R8: between reads the held code never gets quieter
   a_r8_min_only: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> code_q <= $past(code_q));
   // R9: with no accepted sample and no read the code is held
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(en && smp_vld)) |=> $stable(code_q));
   // R7: a read with no new sample returns the tracker to the quiet code
   a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !smp_vld) |=> code_q == QUIET);
endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port #(
   parameter int ADDR_W    = spi_ctrl_pkg::DEF_ADDR_W,
   parameter int DATA_W    = spi_ctrl_pkg::DEF_DATA_W,
   parameter int CODE_W    = spi_ctrl_pkg::DEF_CODE_W,
   parameter int N_PEAK    = spi_ctrl_pkg::DEF_N_PEAK,
   parameter int PEAK_BASE = spi_ctrl_pkg::DEF_PEAK_BASE,
   parameter int RSV_ADDR  = spi_ctrl_pkg::DEF_RSV_ADDR,
   parameter int VOL_LO    = spi_ctrl_pkg::DEF_VOL_LO,
   parameter int VOL_HI    = spi_ctrl_pkg::DEF_VOL_HI,
   parameter int EN_REG    = spi_ctrl_pkg::DEF_EN_REG,
   parameter int EN_BIT    = spi_ctrl_pkg::DEF_EN_BIT,
   parameter int SYNC      = spi_ctrl_pkg::DEF_SYNC,
   localparam int N_REG    = 1 << ADDR_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     spi_cs_n,
   input  logic                     spi_sck,
   input  logic                     spi_mosi,
   output logic                     spi_miso,
   output logic                     spi_miso_oe,
   input  logic [N_PEAK-1:0]        pk_vld,
   input  logic [N_PEAK*CODE_W-1:0] pk_code,
   output logic [N_REG*DATA_W-1:0]  cfg_q
);
   initial begin
      assert (DATA_W > CODE_W) else $error("peak code must fit in a data word");
      assert (PEAK_BASE + N_PEAK <= N_REG) else $error("peak slots outside bank");
      assert (EN_REG < N_REG && EN_BIT < DATA_W) else $error("enable bit outside bank");
   end

   logic [2:0]        pins_s;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [DATA_W-1:0] rd_word, wr_data;
   logic              rd_stb, wr_stb, peak_en;
   logic [DATA_W-1:0] cfg_w [N_REG];
   logic [CODE_W-1:0] pk_q  [N_PEAK];

   spi_ctrl_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b100)) u_sync (
      .clk (clk), .rst_n (rst_n),
      .d   ({spi_cs_n, spi_sck, spi_mosi}),
      .q   (pins_s)
   );

   spi_ctrl_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk     (clk),       .rst_n   (rst_n),
      .cs_s    (pins_s[2]), .sck_s   (pins_s[1]), .mosi_s (pins_s[0]),
      .rd_word (rd_word),   .rd_addr (rd_addr),   .rd_stb (rd_stb),
      .wr_stb  (wr_stb),    .wr_addr (wr_addr),   .wr_data (wr_data),
      .miso    (spi_miso),  .miso_oe (spi_miso_oe)
   );

   spi_ctrl_regs #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .N_PEAK (N_PEAK), .PEAK_BASE (PEAK_BASE),
      .RSV_ADDR (RSV_ADDR), .VOL_LO (VOL_LO), .VOL_HI (VOL_HI)
   ) u_regs (
      .clk (clk), .rst_n (rst_n),
      .wr_stb (wr_stb), .wr_addr (wr_addr), .wr_data (wr_data),
      .cfg_q (cfg_q)
   );

   for (genvar w = 0; w < N_REG; w++) begin : g_word
      assign cfg_w[w] = cfg_q[w*DATA_W +: DATA_W];
   end

   assign peak_en = cfg_w[EN_REG][EN_BIT];

   for (genvar c = 0; c < N_PEAK; c++) begin : g_peak
      logic clr_c;
      assign clr_c = rd_stb && (rd_addr == ADDR_W'(PEAK_BASE + c));
      spi_ctrl_peak #(.CODE_W(CODE_W)) u_peak (
         .clk (clk), .rst_n (rst_n), .en (peak_en), .clr (clr_c),
         .smp_vld (pk_vld[c]), .smp_code (pk_code[c*CODE_W +: CODE_W]),
         .code_q (pk_q[c])
      );
   end

   always_comb begin
      rd_word = cfg_w[rd_addr];
      for (int c = 0; c < N_PEAK; c++) begin
         if (rd_addr == ADDR_W'(PEAK_BASE + c))
            rd_word = {pk_q[c], {(DATA_W-CODE_W){1'b0}}};
      end
   end
endmodule

// File: tb/spi_ctrl_port_tb_top.sv
`timescale 1ns/1ps
module spi_ctrl_port_tb_top;
   localparam int H = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
   logic         spi_miso, spi_miso_oe;
   logic [1:0]   pk_vld = '0;
   logic [11:0]  pk_code = '0;
   logic [159:0] cfg_q;

   int total = 0, bad = 0;
   bit done = 0;
   logic [9:0] exp_q[$];
   string      tag_q[$];
   logic [9:0] got_q[$];

   always #2 clk = ~clk;

   spi_ctrl_port dut_i (
      .clk (clk), .rst_n (rst_n), .spi_cs_n (spi_cs_n), .spi_sck (spi_sck),
      .spi_mosi (spi_mosi), .spi_miso (spi_miso), .spi_miso_oe (spi_miso_oe),
      .pk_vld (pk_vld), .pk_code (pk_code), .cfg_q (cfg_q)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [9:0] word(input int n);
      return cfg_q[n*10 +: 10];
   endfunction

   task automatic xfer(input logic [15:0] f, input int nbits, output logic [9:0] rd);
      rd = '0;
      spi_cs_n = 1'b0;
      wait_clk(H);
      for (int i = 0; i < nbits; i++) begin
         spi_sck  = 1'b0;
         spi_mosi = (i < 16) ? f[15-i] : 1'b0;
         wait_clk(H);
         if (i >= 6 && i < 16) rd = {rd[8:0], spi_miso};
         spi_sck = 1'b1;
         wait_clk(H);
      end
      spi_sck = 1'b0;
      wait_clk(H);
      spi_cs_n = 1'b1;
      wait_clk(2*H);
   endtask

   task automatic wr(input int a, input int d, input int nbits, input bit rsv);
      logic [9:0] rd;
      xfer({4'(a), 1'b0, rsv, 10'(d)}, nbits, rd);
   endtask

   task automatic rd_chk(input int a, input int e, input string tag);
      logic [9:0] rd;
      exp_q.push_back(10'(e));
      tag_q.push_back(tag);
      xfer({4'(a), 1'b1, 1'b0, 10'h000}, 16, rd);
      got_q.push_back(rd);
   endtask

   task automatic pk(input int ch, input int code);
      pk_code[ch*6 +: 6] = 6'(code);
      pk_vld[ch] = 1'b1;
      wait_clk(1);
      pk_vld[ch] = 1'b0;
      wait_clk(1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         logic [9:0] g, e;
         string t;
         wait (got_q.size() > 0);
         g = got_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(g === e, t, g, e);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      // R4 / R10 reset contents, R1 idle pins
      for (int n = 0; n < 16; n++) begin
         int e;
         e = (n >= 2 && n <= 9) ? 10'h3FF : 10'h000;
         chk(word(n) == 10'(e), $sformatf("R4 R10 reset word %0d", n), word(n), e);
      end
      chk(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R1 idle driver off", spi_miso_oe, 0);

      // R1 driver enabled inside a frame
      spi_cs_n = 1'b0;
      wait_clk(6);
      chk(spi_miso_oe == 1'b1 && spi_miso == 1'b0, "R1 driver on in frame", spi_miso_oe, 1);
      spi_cs_n = 1'b1;
      wait_clk(6);
      chk(spi_miso_oe == 1'b0, "R1 driver off after frame", spi_miso_oe, 0);

      // R6 reads of reset values
      rd_chk(3, 10'h3FF, "R6 R4 read word 3");
      rd_chk(0, 10'h000, "R6 R4 read word 0");

      // R2 R3 bit order and commit
      wr(0, 10'h2A5, 16, 1'b0);
      chk(word(0) == 10'h2A5, "R2 R3 write word 0", word(0), 10'h2A5);
      rd_chk(0, 10'h2A5, "R6 R2 read back word 0");
      wr(13, 10'h155, 16, 1'b0);
      chk(word(13) == 10'h155, "R3 R10 write word 13", word(13), 10'h155);
      rd_chk(13, 10'h155, "R6 read back word 13");

      // R3 malformed frames ignored
      wr(4, 10'h000, 15, 1'b0);
      chk(word(4) == 10'h3FF, "R3 short frame ignored", word(4), 10'h3FF);
      wr(4, 10'h000, 17, 1'b0);
      chk(word(4) == 10'h3FF, "R3 long frame ignored", word(4), 10'h3FF);
      wr(5, 10'h000, 16, 1'b1);
      chk(word(5) == 10'h3FF, "R3 reserved bit set ignored", word(5), 10'h3FF);

      // R5 read-only and reserved addresses
      wr(10, 10'h155, 16, 1'b0);
      wr(15, 10'h155, 16, 1'b0);
      chk(word(10) == 10'h000, "R5 slot 10 stays zero", word(10), 0);
      chk(word(15) == 10'h000, "R5 slot 15 stays zero", word(15), 0);
      rd_chk(15, 10'h000, "R5 read reserved");
      rd_chk(11, 10'h3F0, "R7 peak reset code");

      // R9 capture disabled
      pk(0, 5);
      rd_chk(10, 10'h3F0, "R9 sample ignored while disabled");

      // R8 R7 capture enabled
      wr(14, 10'h001, 16, 1'b0);
      chk(word(14) == 10'h001, "R10 enable word 14", word(14), 1);
      pk(0, 20); pk(0, 7); pk(0, 30); pk(1, 12);
      rd_chk(10, 10'h070, "R8 R7 channel 0 minimum");
      rd_chk(10, 10'h3F0, "R7 cleared after read");
      rd_chk(11, 10'h0C0, "R8 channel 1 minimum");
      pk(1, 0);
      rd_chk(11, 10'h000, "R8 loudest code");

      wait_clk(4);
      wait (got_q.size() == 0);
      wait_clk(2);
      finish_run();
   end
endmodule